// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block produces four clock groups from one master clock: a CPU group, a gated PCI group, a free-running PCI clock and a reference group. Each group comes from its own phase counter, so every output is a registered square wave with a high phase of `*_HALF` master cycles. Three asynchronous active-low controls act on the groups. One stops the CPU group and one stops the gated PCI group. The third powers down the whole block.

Every control passes through a two-flop synchronizer. The two stop requests are then registered only at the rising point of the free-running PCI clock. Each group has a gate state machine with the states RUN, STOPPING, OFF and STARTING. The transitions are: RUN to STOPPING when a stop is registered, STOPPING back to RUN when the request is withdrawn, STOPPING to OFF after LAT low-phase starts, OFF to STARTING on release, STARTING back to OFF on a new request, and STARTING to RUN after LAT low-phase starts. A gate enable changes only at the cycle where its clock is about to go low. As a result a clock always stops low and always restarts with a full high phase.

The power state machine has the states DOWN, WAIT and UP. It moves DOWN to WAIT when the synchronized power control releases, WAIT to UP after `PWRUP_REFS` reference periods, and from WAIT or UP to DOWN when power-down is asserted. Outside UP every output is held low and `clocks_valid` is low.

Top module: `clkctl_top`

## Requirements
- R1: While `rst_n` is low, every clock output and `clocks_valid` are 0.
- R2: `cpu_stop_n`, `pci_stop_n` and `pwr_dn_n` each pass through two master-clock flops. The synchronized stop levels are captured only in the master cycle where the free-running PCI phase counter wraps, which is the cycle before that clock rises.
- R3: When the captured CPU stop request changes, the CPU gate enable follows at the CPU_LAT-th CPU low-phase start (default 2) after the change. Stopped CPU outputs stay at 0.
- R4: When the captured PCI stop request changes, the gated PCI enable follows at the first PCI low-phase start after the change. Stopped gated PCI outputs stay at 0.
- R5: `pci_free_o` and `ref_clk_o` are never affected by the stop inputs. While powered up they toggle with periods 2*PCI_HALF and 2*REF_HALF.
- R6: Every high pulse on any output lasts exactly that group's `*_HALF` master cycles, so no runt pulse appears.
- R7: Once synchronized power-down is seen, each output goes to 0 at its next low-phase start and stays at 0. Both stop inputs have no visible effect during power-down.
- R8: After the synchronized power-down release, `clocks_valid` stays 0 and all outputs stay held for `PWRUP_REFS` reference rising points. `clocks_valid` then goes to 1, and each clock resumes at its next low-phase start.
- R9: If power-down is asserted again during WAIT, the power-up count is discarded, and a later release starts the full count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous CPU group stop, active low |
| pci_stop_n | input | 1 | Asynchronous gated PCI group stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down, active low |
| cpu_clk_o | output | NCPU | CPU clock copies |
| pci_clk_o | output | NPCI | Gated PCI clock copies |
| pci_free_o | output | 1 | Free-running PCI clock |
| ref_clk_o | output | NREF | Reference clock copies |
| clocks_valid | output | 1 | High once the power-up delay has elapsed |

## Verification
A gate machine stuck in a wrong state shows up at a CPU or PCI output as a pulse that is missing or extra. Because the reference model is compared every cycle, this is caught within one group period of the faulty transition. A wrong power-up count moves the rising edge of `clocks_valid` by whole reference periods, which the per-cycle compare and the measured delay expose. A gate updated at the wrong phase produces a high pulse shorter than `*_HALF`, and the pulse-width monitor reports it at the falling edge that ends that pulse.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    typedef enum logic [1:0] {
        G_RUN,
        G_STOPPING,
        G_OFF,
        G_STARTING
    } gate_state_t;

    typedef enum logic [1:0] {
        P_DOWN,
        P_WAIT,
        P_UP
    } pwr_state_t;
endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
    parameter int unsigned      W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/clkctl_phase.sv
module clkctl_phase #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic fall_pt,
    output logic rise_pt,
    output logic lvl_next
);
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    assign fall_pt  = (cnt_q == CW'(HALF - 1));
    assign rise_pt  = (cnt_q == CW'(PERIOD - 1));
    assign cnt_nxt  = rise_pt ? '0 : cnt_q + 1'b1;
    assign lvl_next = (cnt_nxt < CW'(HALF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate
    import clkctl_pkg::*;
#(
    parameter int unsigned LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_pt,
    input  logic lvl_next,
    input  logic stop_req,
    input  logic pwr_on,
    output logic clk_o
);
    localparam int unsigned    LW   = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [LW-1:0]  LAST = LW'(LAT - 1);

    gate_state_t   st_q, st_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic          en_q, en_d, out_d, grp_on;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            G_RUN: begin
                if (stop_req) begin
                    st_d  = G_STOPPING;
                    cnt_d = '0;
                end
            end
            G_STOPPING: begin
                if (!stop_req) begin
                    st_d = G_RUN;
                end else if (fall_pt) begin
                    if (cnt_q == LAST) st_d = G_OFF;
                    else               cnt_d = cnt_q + 1'b1;
                end
            end
            G_OFF: begin
                if (!stop_req) begin
                    st_d  = G_STARTING;
                    cnt_d = '0;
                end
            end
            G_STARTING: begin
                if (stop_req) begin
                    st_d = G_OFF;
                end else if (fall_pt) begin
                    if (cnt_q == LAST) st_d = G_RUN;
                    else               cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = G_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= G_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs: enable moves only where the clock is about to go low
    assign grp_on = (st_d == G_RUN) || (st_d == G_STOPPING);
    assign en_d   = fall_pt ? (grp_on && pwr_on) : en_q;
    assign out_d  = en_d && lvl_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            en_q  <= en_d;
            clk_o <= out_d;
        end
    end
endmodule

// File: rtl/clkctl_pwr.sv
module clkctl_pwr
    import clkctl_pkg::*;
#(
    parameter int unsigned PWRUP_REFS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic ref_rise,
    output logic pwr_on,
    output logic clocks_valid
);
    localparam int unsigned   PW   = $clog2(PWRUP_REFS + 1);
    localparam logic [PW-1:0] LAST = PW'(PWRUP_REFS - 1);

    pwr_state_t    st_q, st_d;
    logic [PW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            P_DOWN: begin
                if (pwr_ok) begin
                    st_d  = P_WAIT;
                    cnt_d = '0;
                end
            end
            P_WAIT: begin
                if (!pwr_ok) begin
                    st_d = P_DOWN;
                end else if (ref_rise) begin
                    if (cnt_q == LAST) st_d = P_UP;
                    else               cnt_d = cnt_q + 1'b1;
                end
            end
            P_UP: begin
                if (!pwr_ok) st_d = P_DOWN;
            end
            default: st_d = P_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= P_DOWN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign pwr_on = (st_q == P_UP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clocks_valid <= 1'b0;
        else        clocks_valid <= (st_d == P_UP);
    end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
    parameter int unsigned NCPU       = 4,
    parameter int unsigned NPCI       = 7,
    parameter int unsigned NREF       = 3,
    parameter int unsigned CPU_HALF   = 2,
    parameter int unsigned PCI_HALF   = 6,
    parameter int unsigned REF_HALF   = 7,
    parameter int unsigned CPU_LAT    = 2,
    parameter int unsigned PCI_LAT    = 1,
    parameter int unsigned PWRUP_REFS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pwr_dn_n,
    output logic [NCPU-1:0] cpu_clk_o,
    output logic [NPCI-1:0] pci_clk_o,
    output logic            pci_free_o,
    output logic [NREF-1:0] ref_clk_o,
    output logic            clocks_valid
);
    localparam int unsigned NGRP   = 4;
    localparam int unsigned G_CPU  = 0;
    localparam int unsigned G_PCI  = 1;
    localparam int unsigned G_FREE = 2;
    localparam int unsigned G_REF  = 3;
    localparam int unsigned GH [NGRP] = '{CPU_HALF, PCI_HALF, PCI_HALF, REF_HALF};
    localparam int unsigned GL [NGRP] = '{CPU_LAT, PCI_LAT, 1, 1};

    logic [2:0]      sync_v;
    logic            cpu_req_q, pci_req_q, pwr_on;
    logic [NGRP-1:0] fall_v, rise_v, lvl_v, req_v, clk_v;

    clkctl_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
        .sync_o  (sync_v)
    );

    // stop requests are taken at the free-running PCI rising point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_req_q <= 1'b0;
            pci_req_q <= 1'b0;
        end else if (rise_v[G_FREE]) begin
            cpu_req_q <= !sync_v[0];
            pci_req_q <= !sync_v[1];
        end
    end

    assign req_v = {1'b0, 1'b0, pci_req_q, cpu_req_q};

    clkctl_pwr #(.PWRUP_REFS(PWRUP_REFS)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_ok       (sync_v[2]),
        .ref_rise     (rise_v[G_REF]),
        .pwr_on       (pwr_on),
        .clocks_valid (clocks_valid)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        clkctl_phase #(.HALF(GH[g])) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .fall_pt  (fall_v[g]),
            .rise_pt  (rise_v[g]),
            .lvl_next (lvl_v[g])
        );
        clkctl_gate #(.LAT(GL[g])) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .fall_pt  (fall_v[g]),
            .lvl_next (lvl_v[g]),
            .stop_req (req_v[g]),
            .pwr_on   (pwr_on),
            .clk_o    (clk_v[g])
        );
    end

    assign cpu_clk_o  = {NCPU{clk_v[G_CPU]}};
    assign pci_clk_o  = {NPCI{clk_v[G_PCI]}};
    assign pci_free_o = clk_v[G_FREE];
    assign ref_clk_o  = {NREF{clk_v[G_REF]}};
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
    parameter int unsigned CPU_HALF = 2,
    parameter int unsigned PCI_HALF = 6,
    parameter int unsigned REF_HALF = 7,
    parameter int unsigned CPU_LAT  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_stop_n,
    input logic pci_stop_n,
    input logic pwr_dn_n,
    input logic cpu_clk,
    input logic pci_clk,
    input logic pci_free,
    input logic ref_clk,
    input logic clocks_valid
);
    localparam int unsigned MAXH   = (REF_HALF > PCI_HALF) ? REF_HALF : PCI_HALF;
    localparam int unsigned PD_LIM = 5 + 2 * MAXH;
    localparam int unsigned CS_LIM = 5 + 2 * PCI_HALF + (CPU_LAT + 1) * 2 * CPU_HALF;
    localparam int unsigned PS_LIM = 5 + 4 * PCI_HALF;

    logic [7:0]  hi_cpu, hi_pci;
    logic [15:0] pd_cnt, cs_cnt, ps_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cpu <= '0;
            hi_pci <= '0;
            pd_cnt <= '0;
            cs_cnt <= '0;
            ps_cnt <= '0;
        end else begin
            hi_cpu <= cpu_clk ? hi_cpu + 8'd1 : 8'd0;
            hi_pci <= pci_clk ? hi_pci + 8'd1 : 8'd0;
            pd_cnt <= pwr_dn_n   ? 16'd0 : ((pd_cnt == 16'hFFFF) ? pd_cnt : pd_cnt + 16'd1);
            cs_cnt <= cpu_stop_n ? 16'd0 : ((cs_cnt == 16'hFFFF) ? cs_cnt : cs_cnt + 16'd1);
            ps_cnt <= pci_stop_n ? 16'd0 : ((ps_cnt == 16'hFFFF) ? ps_cnt : ps_cnt + 16'd1);
        end
    end

    assert_cpu_full_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk && $past(cpu_clk)) |-> (hi_cpu == 8'(CPU_HALF)));

    assert_pci_full_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_clk && $past(pci_clk)) |-> (hi_pci == 8'(PCI_HALF)));

    assert_pd_all_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_cnt >= 16'(PD_LIM)) |-> !(cpu_clk || pci_clk || pci_free || ref_clk));

    assert_pd_valid_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_n && $past(!pwr_dn_n) && $past(!pwr_dn_n, 2) && $past(!pwr_dn_n, 3))
        |-> !clocks_valid);

    assert_cpu_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_cnt >= 16'(CS_LIM)) |-> !cpu_clk);

    assert_pci_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_cnt >= 16'(PS_LIM)) |-> !pci_clk);
endmodule

bind clkctl_top clkctl_chk #(
    .CPU_HALF (CPU_HALF),
    .PCI_HALF (PCI_HALF),
    .REF_HALF (REF_HALF),
    .CPU_LAT  (CPU_LAT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_stop_n   (cpu_stop_n),
    .pci_stop_n   (pci_stop_n),
    .pwr_dn_n     (pwr_dn_n),
    .cpu_clk      (cpu_clk_o[0]),
    .pci_clk      (pci_clk_o[0]),
    .pci_free     (pci_free_o),
    .ref_clk      (ref_clk_o[0]),
    .clocks_valid (clocks_valid)
);

// File: tb/clkctl_top_tb.sv
module clkctl_top_tb;
    localparam int NCPU = 4, NPCI = 7, NREF = 3;
    localparam int CPU_HALF = 2, PCI_HALF = 6, REF_HALF = 7;
    localparam int CPU_LAT = 2, PCI_LAT = 1, PWRUP_REFS = 4;
    localparam int REFP = 2 * REF_HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b0;
    logic [NCPU-1:0] cpu_clk_o;
    logic [NPCI-1:0] pci_clk_o;
    logic            pci_free_o;
    logic [NREF-1:0] ref_clk_o;
    logic            clocks_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clkctl_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .pwr_dn_n     (pwr_dn_n),
        .cpu_clk_o    (cpu_clk_o),
        .pci_clk_o    (pci_clk_o),
        .pci_free_o   (pci_free_o),
        .ref_clk_o    (ref_clk_o),
        .clocks_valid (clocks_valid)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int n;
    bit s1 [3];
    bit s2 [3];
    bit creq, preq;
    int pst, pcnt;
    int gst [4];
    int gc  [4];
    bit gen [4];
    bit gout[4];
    bit mvalid;
    int halves [4] = '{CPU_HALF, PCI_HALF, PCI_HALF, REF_HALF};
    int lats   [4] = '{CPU_LAT, PCI_LAT, 1, 1};

    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0;
            s1 = '{1'b1, 1'b1, 1'b0};
            s2 = '{1'b1, 1'b1, 1'b0};
            creq = 0; preq = 0; pst = 0; pcnt = 0; mvalid = 0;
            for (int g = 0; g < 4; g++) begin
                gst[g] = 0; gc[g] = 0; gen[g] = 0; gout[g] = 0;
            end
        end else begin
            bit pon;
            pon = (pst == 2);
            for (int g = 0; g < 4; g++) begin
                int p, ph;
                bit fall, lvl, req;
                p    = 2 * halves[g];
                ph   = n % p;
                fall = (ph == halves[g] - 1);
                lvl  = (((ph + 1) % p) < halves[g]);
                req  = (g == 0) ? creq : ((g == 1) ? preq : 1'b0);
                case (gst[g])
                    0: if (req) begin gst[g] = 1; gc[g] = 0; end
                    1: if (!req) gst[g] = 0;
                       else if (fall) begin
                           if (gc[g] == lats[g] - 1) gst[g] = 2; else gc[g]++;
                       end
                    2: if (!req) begin gst[g] = 3; gc[g] = 0; end
                    default: if (req) gst[g] = 2;
                       else if (fall) begin
                           if (gc[g] == lats[g] - 1) gst[g] = 0; else gc[g]++;
                       end
                endcase
                if (fall) gen[g] = (gst[g] <= 1) && pon;
                gout[g] = gen[g] && lvl;
            end
            case (pst)
                0: if (s2[2]) begin pst = 1; pcnt = 0; end
                1: if (!s2[2]) pst = 0;
                   else if ((n % REFP) == REFP - 1) begin
                       if (pcnt == PWRUP_REFS - 1) pst = 2; else pcnt++;
                   end
                default: if (!s2[2]) pst = 0;
            endcase
            mvalid = (pst == 2);
            if ((n % (2 * PCI_HALF)) == 2 * PCI_HALF - 1) begin
                creq = !s2[0];
                preq = !s2[1];
            end
            s2 = s1;
            s1 = '{cpu_stop_n, pci_stop_n, pwr_dn_n};
            n++;
        end
    end

    // per-cycle compare and pulse-width monitor, away from the active edge
    int run [4];
    bit prev [4];
    always @(negedge clk) begin
        if (rst_n) begin
            bit cur [4];
            chk("R2/R3", int'(cpu_clk_o), int'({NCPU{gout[0]}}), "cpu group");
            chk("R4", int'(pci_clk_o), int'({NPCI{gout[1]}}), "gated pci group");
            chk("R5", int'(pci_free_o), int'(gout[2]), "free pci");
            chk("R5", int'(ref_clk_o), int'({NREF{gout[3]}}), "ref group");
            chk("R8", int'(clocks_valid), int'(mvalid), "clocks_valid");
            cur = '{cpu_clk_o[0], pci_clk_o[0], pci_free_o, ref_clk_o[0]};
            for (int g = 0; g < 4; g++) begin
                if (prev[g] && !cur[g]) chk("R6", run[g], halves[g], "high pulse width");
                run[g]  = cur[g] ? run[g] + 1 : 0;
                prev[g] = cur[g];
            end
        end else begin
            for (int g = 0; g < 4; g++) begin run[g] = 0; prev[g] = 0; end
        end
    end

    task automatic drive_wait(input int cyc);
        repeat (cyc) @(posedge clk);
        #2;
    endtask

    task automatic count_rises(input int cyc, output int crise, output int frise, output int rrise,
                               output int pcnt_hi, output int ccnt_hi);
        bit pc, pf, pr;
        crise = 0; frise = 0; rrise = 0; pcnt_hi = 0; ccnt_hi = 0;
        @(negedge clk);
        pc = cpu_clk_o[0]; pf = pci_free_o; pr = ref_clk_o[0];
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (cpu_clk_o[0] && !pc) crise++;
            if (pci_free_o && !pf) frise++;
            if (ref_clk_o[0] && !pr) rrise++;
            if (pci_clk_o[0]) pcnt_hi++;
            if (cpu_clk_o[0]) ccnt_hi++;
            pc = cpu_clk_o[0]; pf = pci_free_o; pr = ref_clk_o[0];
        end
    endtask

    task automatic measure_valid(input string req, output int cyc);
        cyc = 0;
        while (!clocks_valid && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, int'(cyc >= 3 + (PWRUP_REFS - 1) * REFP + 1), 1, "power-up delay lower bound");
        chk(req, int'(cyc <= 3 + PWRUP_REFS * REFP), 1, "power-up delay upper bound");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cr, fr, rr, ph, chi, cyc;
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", int'({cpu_clk_o, pci_clk_o, pci_free_o, ref_clk_o}), 0, "outputs in reset");
        chk("R1", int'(clocks_valid), 0, "valid in reset");
        drive_wait(1);
        rst_n = 1'b1;

        // R7: held in power-down, stops toggled with no effect
        drive_wait(10);
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        count_rises(30, cr, fr, rr, ph, chi);
        chk("R7", cr + fr + rr + ph, 0, "activity while powered down");
        drive_wait(1);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        drive_wait(30);

        // R8: power-up delay
        pwr_dn_n = 1'b1;
        measure_valid("R8", cyc);
        drive_wait(30);

        // R5: free-running clocks at their periods while powered up
        count_rises(2 * PCI_HALF * REFP, cr, fr, rr, ph, chi);
        chk("R5", fr, REFP, "free pci rises");
        chk("R5", rr, 2 * PCI_HALF, "ref rises");

        // R3: cpu stop
        drive_wait(1);
        cpu_stop_n = 1'b0;
        drive_wait(40);
        count_rises(48, cr, fr, rr, ph, chi);
        chk("R3", chi, 0, "cpu high cycles while stopped");
        chk("R5", fr, 4, "free pci during cpu stop");
        chk("R4", int'(ph > 0), 1, "gated pci keeps running during cpu stop");
        drive_wait(1);
        cpu_stop_n = 1'b1;
        drive_wait(40);
        count_rises(48, cr, fr, rr, ph, chi);
        chk("R3", cr, 12, "cpu rises after restart");

        // R4: pci stop
        drive_wait(1);
        pci_stop_n = 1'b0;
        drive_wait(40);
        count_rises(48, cr, fr, rr, ph, chi);
        chk("R4", ph, 0, "gated pci high cycles while stopped");
        chk("R5", fr, 4, "free pci during pci stop");
        chk("R3", cr, 12, "cpu unaffected by pci stop");

        // both stops, short pulses on cpu stop to exercise STOPPING/STARTING paths
        drive_wait(1);
        cpu_stop_n = 1'b0;
        drive_wait(7);
        cpu_stop_n = 1'b1;
        drive_wait(5);
        cpu_stop_n = 1'b0;
        drive_wait(17);
        cpu_stop_n = 1'b1;
        drive_wait(3);
        cpu_stop_n = 1'b0;
        drive_wait(40);
        count_rises(56, cr, fr, rr, ph, chi);
        chk("R5", rr, 4, "ref during both stops");
        drive_wait(1);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        drive_wait(40);

        // R7: power-down entry from running state
        pwr_dn_n = 1'b0;
        drive_wait(25);
        cpu_stop_n = 1'b0;
        count_rises(40, cr, fr, rr, ph, chi);
        chk("R7", cr + fr + rr + ph, 0, "activity after power-down entry");
        chk("R7", int'(clocks_valid), 0, "valid during power-down");
        drive_wait(1);
        cpu_stop_n = 1'b1;

        // R9: release, abort mid-count, release again
        pwr_dn_n = 1'b1;
        drive_wait(30);
        chk("R9", int'(clocks_valid), 0, "valid before count done");
        pwr_dn_n = 1'b0;
        drive_wait(10);
        pwr_dn_n = 1'b1;
        measure_valid("R9", cyc);
        drive_wait(100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule